// File: doc/BRIEF.md
# Battery Switchover Controller

This block decides whether the output rail is fed from the main supply or from the backup battery. It looks at three comparator flags that have already been synchronized to its clock. The first says the main supply is above its trip level. The second says the main supply is above the battery plus a 30 mV margin. The third says the main supply is below the battery minus that margin. From these it drives one enable for each pass switch. It also drives a battery-on status, which turns off an external pass transistor, and a backup flag, which blocks serial communication. It emits a one-cycle event whenever backup mode begins or ends, so that other blocks can stop and restart their timebase.

While the main supply is above its trip level, the rail always stays on the main supply. Below the trip level the two margin flags form a hysteresis band. The rail moves to the battery only when the main supply is clearly below the battery. It moves back only when the main supply is clearly above it. Inside the band, or when the flags contradict each other, the current source is kept. Every change of source passes through a break-before-make gap of `GAP_CYC` clock cycles, during which neither switch is enabled.

Top module: `batt_switch_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, `main_sw_en` is 1 and `batt_sw_en`, `batt_on`, `comm_block` and `mode_evt` are all 0.
- R2: While `main_above_trip` is 1, the rail selects the main supply. If the rail is on the main supply it stays there. If it is on the battery, a move back to the main supply starts on the next clock edge. This holds whatever the margin flags show.
- R3: With `main_above_trip` at 0, `main_below_bat` at 1 and `main_above_bat` at 0, a rail that is on the main supply moves to the battery.
- R4: With `main_above_trip` at 0, `main_above_bat` at 1 and `main_below_bat` at 0, a rail that is on the battery moves back to the main supply.
- R5: With `main_above_trip` at 0 and both margin flags at 0 (inside the hysteresis band), the current selection is held.
- R6: With `main_above_trip` at 0 and both margin flags at 1 (inconsistent), the current selection is held.
- R7: A change of source begins on the clock edge that sees the request. It then holds both `main_sw_en` and `batt_sw_en` at 0 for exactly `GAP_CYC` cycles, and the new enable rises on the edge after that. The two enables are never 1 together.
- R8: Once a gap has started, it runs to completion and the new source is enabled, even if the request reverses during the gap. The reversed request is then served by a further gap.
- R9: `batt_on` is 0 exactly while the rail is on the main supply. It is 1 from the start of a gap toward the battery until the main supply is enabled again.
- R10: `comm_block` rises in the cycle in which `batt_sw_en` rises. It falls in the cycle in which `main_sw_en` rises again.
- R11: `mode_evt` is 1 for exactly one cycle, the first cycle in which `comm_block` has a new value, and is 0 otherwise.
- R12: With no battery fitted (`main_above_bat` at 1, `main_below_bat` at 0) and the main supply above trip, the rail stays on the main supply with no backup activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_above_trip | input | 1 | Main supply is above its trip level |
| main_above_bat | input | 1 | Main supply exceeds battery plus margin |
| main_below_bat | input | 1 | Main supply is below battery minus margin |
| main_sw_en | output | 1 | Enables the main-supply pass switch |
| batt_sw_en | output | 1 | Enables the battery pass switch |
| batt_on | output | 1 | High when the rail is not on the main supply; turns off the external transistor |
| comm_block | output | 1 | Backup mode; blocks serial communication |
| mode_evt | output | 1 | One-cycle pulse on entry to or exit from backup mode |

## Verification
The flags are applied in several patterns. In normal operation without a battery, the flags show the main supply above trip and above the battery. A trip-high pattern combined with a low margin flag shows that the trip flag overrides the hysteresis. The in-band and contradictory patterns are each applied once on the main supply and once on the battery, which separates holding the selection from falling back to a fixed default. A request that reverses in the middle of a gap, and a trip recovery while on the battery, show that a gap always runs its full length. These sequences also show the exact cycles at which the enables, the battery-on status, the backup flag and the event pulse change.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    typedef struct packed {
        logic above_trip;
        logic above_hi;
        logic below_lo;
    } cmp_t;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_BATT = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        ST_MAIN  = 2'b00,
        ST_BRK_B = 2'b01,
        ST_BATT  = 2'b11,
        ST_BRK_M = 2'b10
    } st_e;

    typedef struct packed {
        logic main_en;
        logic batt_en;
        logic batt_on;
        logic inhibit;
    } drv_t;

    function automatic src_e pick_src(cmp_t c, src_e cur);
        if (c.above_trip)                  return SRC_MAIN;
        if (c.below_lo && !c.above_hi)     return SRC_BATT;
        if (c.above_hi && !c.below_lo)     return SRC_MAIN;
        return cur;
    endfunction

    function automatic logic is_backup(st_e s);
        return (s == ST_BATT) || (s == ST_BRK_M);
    endfunction

    function automatic drv_t decode(st_e s);
        drv_t d;
        d.main_en = (s == ST_MAIN);
        d.batt_en = (s == ST_BATT);
        d.batt_on = (s != ST_MAIN);
        d.inhibit = is_backup(s);
        return d;
    endfunction

endpackage

// File: rtl/bsw_decide.sv
module bsw_decide
    import bsw_pkg::*;
(
    input  cmp_t cmp,
    input  src_e cur_src,
    output src_e want_src
);
    always_comb want_src = pick_src(cmp, cur_src);
endmodule

// File: rtl/bsw_seq.sv
module bsw_seq
    import bsw_pkg::*;
#(
    parameter int GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  src_e want_src,
    output st_e  st,
    output st_e  st_nxt,
    output src_e cur_src
);
    localparam int CW = $clog2(GAP_CYC) + 1;
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_nxt = st;
        cnt_d  = cnt_q;
        unique case (st)
            ST_MAIN: if (want_src == SRC_BATT) begin
                st_nxt = ST_BRK_B;
                cnt_d  = GAP_LOAD;
            end
            ST_BATT: if (want_src == SRC_MAIN) begin
                st_nxt = ST_BRK_M;
                cnt_d  = GAP_LOAD;
            end
            ST_BRK_B: if (cnt_q == '0) st_nxt = ST_BATT; else cnt_d = cnt_q - 1'b1;
            ST_BRK_M: if (cnt_q == '0) st_nxt = ST_MAIN; else cnt_d = cnt_q - 1'b1;
            default: st_nxt = ST_MAIN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_MAIN;
            cnt_q <= '0;
        end else begin
            st    <= st_nxt;
            cnt_q <= cnt_d;
        end
    end

    // selection seen by the decision logic: last source actually connected
    assign cur_src = (st == ST_BATT || st == ST_BRK_M) ? SRC_BATT : SRC_MAIN;

    // R8: a started gap is never abandoned
    a_r8_gap_commit_b: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BRK_B) |=> (st == ST_BRK_B || st == ST_BATT));
    a_r8_gap_commit_m: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BRK_M) |=> (st == ST_BRK_M || st == ST_MAIN));
    // R7: a gap is left only when the counter has run out
    a_r7_gap_len: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BRK_B && cnt_q != '0) |=> (st == ST_BRK_B));
endmodule

// File: rtl/bsw_event.sv
module bsw_event
    import bsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  st_e  st,
    input  st_e  st_nxt,
    output logic evt
);
    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= is_backup(st_nxt) != is_backup(st);
    end
endmodule

// File: rtl/batt_switch_ctrl.sv
module batt_switch_ctrl
    import bsw_pkg::*;
#(
    parameter int GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic main_above_trip,
    input  logic main_above_bat,
    input  logic main_below_bat,
    output logic main_sw_en,
    output logic batt_sw_en,
    output logic batt_on,
    output logic comm_block,
    output logic mode_evt
);
    cmp_t cmp;
    src_e cur_src, want_src;
    st_e  st, st_nxt;
    drv_t drv;

    assign cmp = '{above_trip: main_above_trip, above_hi: main_above_bat, below_lo: main_below_bat};

    bsw_decide u_decide (
        .cmp      (cmp),
        .cur_src  (cur_src),
        .want_src (want_src)
    );

    bsw_seq #(.GAP_CYC(GAP_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .want_src (want_src),
        .st       (st),
        .st_nxt   (st_nxt),
        .cur_src  (cur_src)
    );

    bsw_event u_evt (
        .clk (clk),
        .rst (rst),
        .st  (st),
        .st_nxt (st_nxt),
        .evt (mode_evt)
    );

    always_comb drv = decode(st);
    assign main_sw_en = drv.main_en;
    assign batt_sw_en = drv.batt_en;
    assign batt_on    = drv.batt_on;
    assign comm_block = drv.inhibit;

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(main_sw_en && batt_sw_en));
    a_r7_break_first: assert property (@(posedge clk) disable iff (rst)
        $fell(main_sw_en) |-> !batt_sw_en);
    a_r2_trip_keeps_main: assert property (@(posedge clk) disable iff (rst)
        (main_above_trip && main_sw_en) |=> main_sw_en);
    a_r5_band_hold: assert property (@(posedge clk) disable iff (rst)
        (!main_above_trip && !main_above_bat && !main_below_bat && batt_sw_en) |=> batt_sw_en);
    a_r6_conflict_hold: assert property (@(posedge clk) disable iff (rst)
        (!main_above_trip && main_above_bat && main_below_bat && main_sw_en) |=> main_sw_en);
    a_r11_evt_on_change: assert property (@(posedge clk) disable iff (rst)
        (comm_block != $past(comm_block)) |-> mode_evt);
    a_r11_evt_only_change: assert property (@(posedge clk) disable iff (rst)
        mode_evt |-> (comm_block != $past(comm_block)));
    a_r10_block_with_batt: assert property (@(posedge clk) disable iff (rst)
        $rose(batt_sw_en) |-> $rose(comm_block));
endmodule

// File: tb/tb_batt_switch_ctrl.sv
module tb_batt_switch_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trip = 1'b1, hi = 1'b1, lo = 1'b0;
    logic main_sw_en, batt_sw_en, batt_on, comm_block, mode_evt;

    typedef struct {
        logic [4:0] val;   // main_en, batt_en, batt_on, block, evt
        string      tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    batt_switch_ctrl #(.GAP_CYC(3)) dut (
        .clk(clk), .rst(rst),
        .main_above_trip(trip), .main_above_bat(hi), .main_below_bat(lo),
        .main_sw_en(main_sw_en), .batt_sw_en(batt_sw_en), .batt_on(batt_on),
        .comm_block(comm_block), .mode_evt(mode_evt)
    );

    localparam logic [4:0] M   = 5'b10000;
    localparam logic [4:0] ME  = 5'b10001;
    localparam logic [4:0] GB  = 5'b00100;
    localparam logic [4:0] B   = 5'b01110;
    localparam logic [4:0] BE  = 5'b01111;
    localparam logic [4:0] GM  = 5'b00110;

    task automatic step(input logic t, input logic h, input logic l,
                        input logic [4:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        trip = t; hi = h; lo = l;
        x.val = e; x.tag = tag;
        q.push_back(x);
    endtask

    // monitor: results of each edge are compared shortly after it
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t x;
            logic [4:0] act;
            x = q.pop_front();
            act = {main_sw_en, batt_sw_en, batt_on, comm_block, mode_evt};
            total++;
            if (act !== x.val) begin
                bad++;
                $display("FAIL %s: got %b expected %b", x.tag, act, x.val);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(1, 1, 0, M, "R1 reset");
        step(1, 1, 0, M, "R1 reset");
        @(negedge clk); rst = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 3; i++) step(1, 1, 0, M, "R12 no battery");
        for (int i = 0; i < 2; i++) step(1, 0, 1, M, "R2 trip overrides low flag");
        for (int i = 0; i < 2; i++) step(0, 0, 0, M, "R5 band hold on main");
        for (int i = 0; i < 2; i++) step(0, 1, 1, M, "R6 conflict hold on main");
        // to battery
        for (int i = 0; i < 3; i++) step(0, 0, 1, GB, "R7 R9 gap to battery");
        step(0, 0, 1, BE, "R3 R10 R11 battery enabled");
        step(0, 0, 1, B,  "R11 single pulse");
        for (int i = 0; i < 2; i++) step(0, 0, 0, B, "R5 band hold on battery");
        step(0, 1, 1, B, "R6 conflict hold on battery");
        // back to main
        for (int i = 0; i < 3; i++) step(0, 1, 0, GM, "R7 R9 gap to main");
        step(0, 1, 0, ME, "R4 R10 R11 main enabled");
        step(0, 1, 0, M,  "R11 single pulse");
        // to battery again, then trip recovery
        for (int i = 0; i < 3; i++) step(0, 0, 1, GB, "R7 gap to battery");
        step(0, 0, 1, BE, "R3 battery enabled");
        for (int i = 0; i < 3; i++) step(1, 0, 1, GM, "R2 trip forces gap to main");
        step(1, 0, 1, ME, "R2 R11 main after trip");
        step(1, 0, 1, M,  "R2 stays main");
        // reversal in the middle of a gap
        step(0, 0, 1, GB, "R8 gap starts");
        step(0, 1, 0, GB, "R8 gap continues after reversal");
        step(0, 1, 0, GB, "R8 gap continues after reversal");
        step(0, 1, 0, BE, "R8 gap completes to battery");
        for (int i = 0; i < 3; i++) step(0, 1, 0, GM, "R8 reversal served by new gap");
        step(0, 1, 0, ME, "R8 R11 back on main");
        step(1, 1, 0, M,  "R12 normal again");
        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            bad++;
            $display("FAIL queue: got %0d left expected 0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule